// File: doc/BRIEF.md
# SPI Mailbox Shift Chain

This block connects a wide parallel host port to a small microcontroller that runs as SPI master. The host posts a 32-bit word together with an 8-bit tag (latched address and transfer-size bits) in a single write. The microcontroller later pulses a transfer strobe to move that posted word into the outgoing frame. It then runs one SPI transfer that clocks the 40-bit frame out on MISO while shifting a 32-bit reply in on MOSI. When the transfer completes, the reply becomes visible on the host read port.

The outgoing side has two layers: a holding register filled by the host and a frame snapshot filled by the strobe. Because of this, the host can post its next word while the current frame is still being shifted. The output bit is registered on the plain SCK falling edge, so every transfer opens with one dummy clock. The host clock and SCK are unrelated. The strobe and the transfer-complete event each enter the host domain through a two-flop synchronizer.

Top module: `spi_mailbox_chain`

## Requirements
- R1: After reset, `host_rd_data` is 0 and an unloaded transfer shifts out 40 zero bits.
- R2: A host write (`host_wr` high at a rising `clk` edge) captures the frame `{host_tag, host_data}` into the holding register. The frame being shifted is not affected.
- R3: With `cs_n` low, the first SCK clock is a dummy and MISO stays 0 before it. The next 40 clocks carry frame bit 39 (tag MSB) down to bit 0 (data LSB). MISO changes after each falling SCK edge, and the master samples it on the rising edge.
- R4: MOSI is sampled on rising SCK edges 2 to 33, MSB first, into a 32-bit reply. After the 41st rising edge, the reply reaches `host_rd_data` within 4 `clk` cycles.
- R5: A rising edge of `xfer_stb` (held high for at least 2 `clk` cycles) copies the holding register into the frame snapshot. Host writes made between strobes do not change the outgoing frame.
- R6: A host write clears `host_rd_data` to 0 on the next `clk` cycle. If a reply commit falls in the same cycle, the commit takes priority.
- R7: Raising `cs_n` resets the bit counter and forces MISO to 0. The next transfer starts again with a dummy clock.
- R8: A transfer ended with fewer than 41 SCK clocks leaves `host_rd_data` unchanged.
- R9: SCK clocks after the 41st drive MISO to 0 and do not commit a second reply.
- R10: The serial path runs from SCK alone, at SCK rates up to 80 MHz, with no `clk` edge needed during shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one `clk` cycle |
| host_data | input | 32 | Host data word |
| host_tag | input | 8 | Latched address and size bits |
| host_rd_data | output | 32 | Reply word for host reads |
| sck | input | 1 | SPI clock from master |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial reply from master |
| miso | output | 1 | Serial frame to master |
| xfer_stb | input | 1 | Snapshot strobe from microcontroller |

## Verification
Four frame/reply pairs are used: all ones, alternating bits, single set bits at both ends, and mixed values. Together they separate a reversed bit order, a missing or extra dummy clock, and a tag/data swap. A host write posted during an active transfer shows whether the two output layers are really independent. A transfer cut short, and one with extra clocks, separate the commit condition from the bit count. The transfers run at 80 MHz against a 125 MHz host clock, which exercises the crossing in both directions.

// File: rtl/spi_mailbox_chain.sv
`timescale 1ns/1ps
module spi_mailbox_chain #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int RESP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic [TAG_W-1:0]  host_tag,
  output logic [RESP_W-1:0] host_rd_data,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              xfer_stb
);
  localparam int FRAME_W = TAG_W + DATA_W;
  localparam int LAST    = FRAME_W + 1;
  localparam int CW      = $clog2(LAST + 1);
  localparam int IW      = $clog2(FRAME_W);

  logic [FRAME_W-1:0] hold_q, snap_q;
  logic [RESP_W-1:0]  resp_q, rx_q;
  logic [2:0]         stb_s, done_s;
  logic               done_tgl, miso_q;
  logic [CW-1:0]      cnt_q;

  wire stb_edge = stb_s[1] & ~stb_s[2];
  wire commit   = done_s[1] ^ done_s[2];

  // host clock domain
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stb_s  <= '0;
      done_s <= '0;
    end else begin
      stb_s  <= {stb_s[1:0], xfer_stb};
      done_s <= {done_s[1:0], done_tgl};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       hold_q <= '0;
    else if (host_wr) hold_q <= {host_tag, host_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        snap_q <= '0;
    else if (stb_edge) snap_q <= hold_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       resp_q <= '0;
    else if (commit)  resp_q <= rx_q;
    else if (host_wr) resp_q <= '0;

  assign host_rd_data = resp_q;

  // serial clock domain
  always_ff @(posedge sck or posedge cs_n)
    if (cs_n)                      cnt_q <= '0;
    else if (cnt_q != CW'(LAST))   cnt_q <= cnt_q + CW'(1);

  always_ff @(posedge sck or negedge rst_n)
    if (!rst_n) begin
      rx_q     <= '0;
      done_tgl <= 1'b0;
    end else if (!cs_n) begin
      if (cnt_q >= CW'(1) && cnt_q <= CW'(RESP_W))
        rx_q <= {rx_q[RESP_W-2:0], mosi};
      if (cnt_q == CW'(FRAME_W))
        done_tgl <= ~done_tgl;
    end

  always_ff @(negedge sck or posedge cs_n)
    if (cs_n) miso_q <= 1'b0;
    else if (cnt_q >= CW'(1) && cnt_q <= CW'(FRAME_W))
      miso_q <= snap_q[IW'(FRAME_W - int'(cnt_q))];
    else miso_q <= 1'b0;

  assign miso = miso_q;

  a_r2_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> hold_q == $past({host_tag, host_data}));
  a_r5_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
    stb_edge |=> snap_q == $past(hold_q));
  a_r5_snap_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_edge |=> $stable(snap_q));
  a_r6_wr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !commit) |=> host_rd_data == '0);
  a_r8_resp_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !commit) |=> $stable(host_rd_data));
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso);
  a_r3_dummy_low: assert property (@(posedge sck) disable iff (cs_n)
    (cnt_q == '0) |-> !miso);
  a_r9_tail_low: assert property (@(posedge sck) disable iff (cs_n)
    (cnt_q == CW'(LAST)) |-> !miso);
endmodule

// File: tb/spi_mailbox_chain_bench.sv
`timescale 1ns/1ps
module spi_mailbox_chain_bench;
  localparam real CLK_HALF = 4.0;
  localparam real SCK_HALF = 6.25;
  localparam int  NV = 4;
  localparam logic [39:0] VEC_FRAME [NV] = '{
    40'hFF_FFFF_FFFF, 40'hA5_5555_AAAA, 40'h80_0000_0001, 40'h3C_1234_5678};
  localparam logic [31:0] VEC_RESP [NV] = '{
    32'hFFFF_FFFF, 32'hAAAA_5555, 32'h8000_0001, 32'hDEAD_BEEF};

  logic clk = 0, rst_n = 0, host_wr = 0, sck = 0, cs_n = 1, mosi = 0, xfer_stb = 0;
  logic [31:0] host_data = '0;
  logic [7:0]  host_tag = '0;
  logic [31:0] host_rd_data;
  logic        miso;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  spi_mailbox_chain u_spi_mailbox_chain (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
    .host_tag(host_tag), .host_rd_data(host_rd_data), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .xfer_stb(xfer_stb));

  always #(CLK_HALF) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [39:0] f);
    @(negedge clk);
    host_wr = 1; host_tag = f[39:32]; host_data = f[31:0];
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic strobe();
    @(negedge clk); xfer_stb = 1;
    repeat (3) @(negedge clk);
    xfer_stb = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic [31:0] rsp, input int nclk,
                          output logic [39:0] got, output logic lead, output int tail_hi);
    got = '0; lead = 0; tail_hi = 0;
    cs_n = 0;
    for (int i = 0; i < nclk; i++) begin
      #(SCK_HALF);
      mosi = (i >= 1 && i <= 32) ? rsp[32-i] : 1'b0;
      if (i == 0) lead = miso;
      else if (i <= 40) got[40-i] = miso;
      else if (miso) tail_hi++;
      sck = 1; #(SCK_HALF); sck = 0;
    end
    #(SCK_HALF); cs_n = 1; #(SCK_HALF);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8.0);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] got;
    logic        lead;
    int          tail;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 rd after reset", 64'(host_rd_data), 64'h0);
    check("R7 miso idle", 64'(miso), 64'h0);
    spi_xfer(32'h0, 41, got, lead, tail);
    check("R1 unloaded frame", 64'(got), 64'h0);

    // vector walk: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      host_write(VEC_FRAME[v]);
      @(negedge clk);
      check("R6 write clears reply", 64'(host_rd_data), 64'h0);
      strobe();
      spi_xfer(VEC_RESP[v], 41, got, lead, tail);
      check("R3 frame out", 64'(got), 64'(VEC_FRAME[v]));
      check("R3 dummy bit low", 64'(lead), 64'h0);
      check("R4 reply in", 64'(host_rd_data), 64'(VEC_RESP[v]));
    end

    // R5 double buffering: post next word mid-transfer
    host_write(40'h11_2233_4455);
    strobe();
    fork
      spi_xfer(32'h0BAD_F00D, 41, got, lead, tail);
      begin #100; host_write(40'h66_7788_99AA); end
    join
    check("R5 frame kept during post", 64'(got), 64'h11_2233_4455);
    check("R2 write mid-transfer clears reply", 64'(host_rd_data), 64'h0BAD_F00D);
    spi_xfer(32'h1357_9BDF, 41, got, lead, tail);
    check("R5 no strobe keeps snapshot", 64'(got), 64'h11_2233_4455);
    check("R4 reply second", 64'(host_rd_data), 64'h1357_9BDF);
    strobe();
    spi_xfer(32'h2468_ACE0, 41, got, lead, tail);
    check("R5 strobe loads posted word", 64'(got), 64'h66_7788_99AA);

    // R8 abort, then R7 restart alignment
    spi_xfer(32'hFFFF_0000, 20, got, lead, tail);
    check("R8 abort keeps reply", 64'(host_rd_data), 64'h2468_ACE0);
    spi_xfer(32'h0F0F_0F0F, 41, got, lead, tail);
    check("R7 restart realigns frame", 64'(got), 64'h66_7788_99AA);
    check("R7 restart dummy low", 64'(lead), 64'h0);
    check("R4 reply after abort", 64'(host_rd_data), 64'h0F0F_0F0F);

    // R9 extra clocks
    spi_xfer(32'h7654_3210, 46, got, lead, tail);
    check("R9 frame with extra clocks", 64'(got), 64'h66_7788_99AA);
    check("R9 tail bits low", 64'(tail), 64'h0);
    check("R9 single commit", 64'(host_rd_data), 64'h7654_3210);
    check("R10 miso idle at end", 64'(miso), 64'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule